// File: doc/BRIEF.md
# Branch Hazard Control Unit

This unit drives the control-hazard signals of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The pipeline has conditional equal-compare branches and register-indirect jumps. Decode presents its opcode to the unit. In the cycle after, execute presents its equality result and computed target, and the unit registers both. One cycle later the branch sits in the memory stage and is resolved there. A taken branch, or any register jump, sends its target to the program counter.

A build-time parameter picks one of two policies. With the stall policy, fetch is frozen and no-ops enter decode while a control instruction travels to the memory stage. Each branch therefore costs exactly three decode bubbles, and fetch then resumes from the target or from the sequential address. With the speculate policy, fetch carries on down the sequential path. When a branch resolves taken, the three younger instructions in decode, execute and memory are turned into no-ops, so none of them can reach writeback. Two free-running counters report the cycles lost to stalls and to squashes, so the cost per instruction of either policy can be measured.

Top module: `branch_hazard_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it with no control opcode in decode, pc_we is 1, pc_sel is 0 and all three flush outputs are 0. Both counters read 0.
- R2: Only a decode opcode equal to BR_OPC (default 4, conditional branch) or JR_OPC (default 5, register jump) counts as a control instruction. Any other opcode, and ex_equal with no branch in execute, changes no output.
- R3: Stall policy: in the detection cycle and the cycle after it, pc_we is 0 and ifid_flush is 1, while idex_flush and exmem_flush stay 0. While a branch is in flight, a control opcode seen in decode is treated as the injected bubble and ignored.
- R4: Stall policy: in the third cycle (branch in memory) ifid_flush is 1 again, giving exactly three bubbles. If not taken, pc_we stays 0. In the next cycle fetch resumes with pc_we=1 and pc_sel=0.
- R5: Speculate policy: detecting a control instruction neither freezes fetch nor flushes anything (pc_we=1, pc_sel=0, all flushes 0).
- R6: Two cycles after detection, a register jump, or a branch whose ex_equal was 1 one cycle after detection, gives pc_we=1, pc_sel=1 (target) and all three flush outputs at 1 for one cycle.
- R7: Speculate policy: a branch whose ex_equal was 0 causes no flush and no redirect. A taken branch directly behind it still redirects one cycle later.
- R8: A control instruction in decode or execute during a squash is discarded and never causes a later redirect.
- R9: A squash overrides a concurrent stall: in the stall policy's third cycle of a taken branch, pc_we is 1 with pc_sel=1 and all three flushes are 1.
- R10: stall_cycles counts cycles with fetch frozen and no squash. squash_cycles counts redirect cycles. Both are per-build, so the speculate build's stall count stays 0.
- R11: When pc_sel is 1, pc_target equals the ex_target presented in the cycle the branch was in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_opcode | input | OPC_W | Opcode of the instruction in decode |
| ex_equal | input | 1 | Operand equality from execute |
| ex_target | input | ADDR_W | Branch target computed in execute |
| pc_we | output | 1 | Program counter write enable |
| pc_sel | output | 1 | 0: sequential address, 1: pc_target |
| pc_target | output | ADDR_W | Redirect address registered in memory stage |
| ifid_flush | output | 1 | Load a no-op into IF/ID |
| idex_flush | output | 1 | Load a no-op into ID/EX |
| exmem_flush | output | 1 | Load a no-op into EX/MEM |
| stall_cycles | output | CNT_W | Count of stall cycles |
| squash_cycles | output | CNT_W | Count of squash cycles |

## Verification
If the unit loses track of a branch, the fault shows two cycles after detection: either a missing redirect with three live flushes absent, or a spurious flush with no control instruction in front of it. A corrupted hold state shows at once as pc_we low for a fourth cycle in the stall build, or pc_we low at all in the speculate build. Wrong counter state appears as a count that drifts from the expected stall and squash totals after a known sequence of taken, untaken and jump instructions.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic {
    PC_SEQ = 1'b0,
    PC_TGT = 1'b1
  } pc_src_e;

  typedef struct packed {
    logic    pc_we;
    pc_src_e pc_sel;
    logic    fl_ifid;
    logic    fl_idex;
    logic    fl_exmem;
  } pipe_ctl_t;

endpackage

// File: rtl/bhc_decode.sv
module bhc_decode #(
  parameter int unsigned OPC_W  = 3,
  parameter int unsigned BR_OPC = 4,
  parameter int unsigned JR_OPC = 5
) (
  input  logic [OPC_W-1:0] id_opcode,
  output logic             id_ctl,
  output logic             id_jmp
);

  localparam logic [OPC_W-1:0] BrCode = OPC_W'(BR_OPC);
  localparam logic [OPC_W-1:0] JrCode = OPC_W'(JR_OPC);

  logic is_br;

  always_comb begin
    is_br  = (id_opcode == BrCode);
    id_jmp = (id_opcode == JrCode);
    id_ctl = is_br | id_jmp;
  end

endmodule

// File: rtl/bhc_track.sv
module bhc_track #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_accept,
  input  logic              id_jmp,
  input  logic              ex_equal,
  input  logic [ADDR_W-1:0] ex_target,
  output logic              ex_br,
  output logic              mem_br,
  output logic              squash,
  output logic [ADDR_W-1:0] mem_tgt
);

  logic ex_br_q, ex_br_d, ex_jmp_q, ex_jmp_d;
  logic mem_br_q, mem_br_d, mem_jmp_q, mem_jmp_d, mem_eq_q, mem_eq_d;
  logic tgt_en;
  logic [ADDR_W-1:0] mem_tgt_q;

  always_comb begin
    squash    = mem_br_q & (mem_jmp_q | mem_eq_q);
    ex_br_d   = id_accept;
    ex_jmp_d  = id_accept & id_jmp;
    mem_br_d  = ex_br_q & ~squash;
    mem_jmp_d = ex_jmp_q;
    mem_eq_d  = ex_equal;
    tgt_en    = ex_br_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_br_q   <= 1'b0;
      ex_jmp_q  <= 1'b0;
      mem_br_q  <= 1'b0;
      mem_jmp_q <= 1'b0;
      mem_eq_q  <= 1'b0;
    end else begin
      ex_br_q   <= ex_br_d;
      ex_jmp_q  <= ex_jmp_d;
      mem_br_q  <= mem_br_d;
      mem_jmp_q <= mem_jmp_d;
      mem_eq_q  <= mem_eq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt_en) begin
      mem_tgt_q <= ex_target;
    end
  end

  assign ex_br   = ex_br_q;
  assign mem_br  = mem_br_q;
  assign mem_tgt = mem_tgt_q;

  AST_SQUASH_KILLS_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !mem_br_q && !squash); // R8

  AST_REDIRECT_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> $past(ex_br_q)); // R6

endmodule

// File: rtl/bhc_policy.sv
module bhc_policy
  import bhc_pkg::*;
#(
  parameter bit SPECULATE = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      id_ctl,
  input  logic      ex_br,
  input  logic      mem_br,
  input  logic      squash,
  output logic      id_accept,
  output logic      stall,
  output pipe_ctl_t ctl
);

  generate
    if (SPECULATE) begin : g_spec
      always_comb begin
        id_accept = id_ctl & ~squash;
        stall     = 1'b0;
      end
    end else begin : g_stall
      always_comb begin
        id_accept = id_ctl & ~squash & ~ex_br & ~mem_br;
        stall     = id_accept | ex_br | mem_br;
      end

      AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_br && mem_br)); // R4

      AST_HOLD_ONLY_WITH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.pc_we |-> ctl.fl_ifid && !ctl.fl_idex && !ctl.fl_exmem); // R3
    end
  endgenerate

  always_comb begin
    ctl.pc_we    = ~stall | squash;
    ctl.pc_sel   = squash ? PC_TGT : PC_SEQ;
    ctl.fl_ifid  = stall | squash;
    ctl.fl_idex  = squash;
    ctl.fl_exmem = squash;
  end

endmodule

// File: rtl/bhc_count.sv
module bhc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             squash,
  output logic [CNT_W-1:0] stall_cyc,
  output logic [CNT_W-1:0] squash_cyc
);

  logic [CNT_W-1:0] stall_q, stall_d, squash_q, squash_d;
  logic             stall_en, squash_en;

  always_comb begin
    stall_en  = stall & ~squash;
    squash_en = squash;
    stall_d   = stall_q + CNT_W'(1);
    squash_d  = squash_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q  <= '0;
      squash_q <= '0;
    end else begin
      if (stall_en)  stall_q  <= stall_d;
      if (squash_en) squash_q <= squash_d;
    end
  end

  assign stall_cyc  = stall_q;
  assign squash_cyc = squash_q;

  AST_STALL_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q == $past(stall_q) || stall_q == CNT_W'($past(stall_q) + 1'b1)); // R10

  AST_SQUASH_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    squash_q == $past(squash_q) || squash_q == CNT_W'($past(squash_q) + 1'b1)); // R10

endmodule

// File: rtl/branch_hazard_ctl.sv
module branch_hazard_ctl
  import bhc_pkg::*;
#(
  parameter int unsigned OPC_W     = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BR_OPC    = 4,
  parameter int unsigned JR_OPC    = 5,
  parameter bit          SPECULATE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  id_opcode,
  input  logic              ex_equal,
  input  logic [ADDR_W-1:0] ex_target,
  output logic              pc_we,
  output logic              pc_sel,
  output logic [ADDR_W-1:0] pc_target,
  output logic              ifid_flush,
  output logic              idex_flush,
  output logic              exmem_flush,
  output logic [CNT_W-1:0]  stall_cycles,
  output logic [CNT_W-1:0]  squash_cycles
);

  logic      id_ctl, id_jmp, id_accept;
  logic      ex_br, mem_br, squash, stall;
  pipe_ctl_t ctl;

  bhc_decode #(.OPC_W(OPC_W), .BR_OPC(BR_OPC), .JR_OPC(JR_OPC)) u_decode (
    .id_opcode (id_opcode),
    .id_ctl    (id_ctl),
    .id_jmp    (id_jmp)
  );

  bhc_track #(.ADDR_W(ADDR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_accept (id_accept),
    .id_jmp    (id_jmp),
    .ex_equal  (ex_equal),
    .ex_target (ex_target),
    .ex_br     (ex_br),
    .mem_br    (mem_br),
    .squash    (squash),
    .mem_tgt   (pc_target)
  );

  bhc_policy #(.SPECULATE(SPECULATE)) u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_ctl    (id_ctl),
    .ex_br     (ex_br),
    .mem_br    (mem_br),
    .squash    (squash),
    .id_accept (id_accept),
    .stall     (stall),
    .ctl       (ctl)
  );

  bhc_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .squash     (squash),
    .stall_cyc  (stall_cycles),
    .squash_cyc (squash_cycles)
  );

  always_comb begin
    pc_we       = ctl.pc_we;
    pc_sel      = ctl.pc_sel;
    ifid_flush  = ctl.fl_ifid;
    idex_flush  = ctl.fl_idex;
    exmem_flush = ctl.fl_exmem;
  end

  AST_TARGET_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> pc_we); // R9

  AST_SQUASH_FLUSHES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_flush |-> ifid_flush && idex_flush && pc_sel); // R6

  AST_FLUSH_IS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    idex_flush |=> !idex_flush); // R8

endmodule

// File: tb/test_branch_hazard_ctl.sv
module test_branch_hazard_ctl;

  typedef struct packed {
    logic [2:0]  opc;
    logic        eq;
    logic [15:0] tgt;
    logic [4:0]  exp_stl;
    logic [4:0]  exp_spc;
    logic [15:0] exp_tgt;
  } vec_t;

  // expected = {pc_we, pc_sel, ifid_flush, idex_flush, exmem_flush}
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}, // idle R2
    '{3'd4, 1'b0, 16'h0000, 5'b00100, 5'b10000, 16'h0000}, // beq detect R3 R5
    '{3'd0, 1'b1, 16'h1234, 5'b00100, 5'b10000, 16'h0000}, // in EX, equal R3
    '{3'd0, 1'b0, 16'h0000, 5'b11111, 5'b11111, 16'h1234}, // taken R6 R9 R11
    '{3'd0, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}, // resume R4
    '{3'd4, 1'b0, 16'h0000, 5'b00100, 5'b10000, 16'h0000}, // beq detect
    '{3'd0, 1'b0, 16'h0BAD, 5'b00100, 5'b10000, 16'h0000}, // not equal
    '{3'd0, 1'b0, 16'h0000, 5'b00100, 5'b10000, 16'h0000}, // third bubble R4 R7
    '{3'd0, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}, // resume R4
    '{3'd5, 1'b0, 16'h0000, 5'b00100, 5'b10000, 16'h0000}, // jump detect
    '{3'd3, 1'b0, 16'h00F0, 5'b00100, 5'b10000, 16'h0000}, // jump, eq ignored
    '{3'd1, 1'b0, 16'h0000, 5'b11111, 5'b11111, 16'h00F0}, // jump taken R6 R11
    '{3'd6, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}, // other opc R2
    '{3'd7, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}, // other opc R2
    '{3'd2, 1'b1, 16'h5555, 5'b10000, 5'b10000, 16'h0000}, // eq w/o branch R2
    '{3'd0, 1'b0, 16'h0000, 5'b10000, 5'b10000, 16'h0000}  // no redirect R2
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  id_opcode;
  logic        ex_equal;
  logic [15:0] ex_target;

  logic        a_we, a_sel, a_fi, a_fd, a_fe;
  logic [15:0] a_tgt, a_stl, a_sq;
  logic        b_we, b_sel, b_fi, b_fd, b_fe;
  logic [15:0] b_tgt, b_stl, b_sq;

  int checks;
  int fails;
  bit done;

  branch_hazard_ctl #(.SPECULATE(1'b0)) i_branch_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .id_opcode(id_opcode), .ex_equal(ex_equal),
    .ex_target(ex_target), .pc_we(a_we), .pc_sel(a_sel), .pc_target(a_tgt),
    .ifid_flush(a_fi), .idex_flush(a_fd), .exmem_flush(a_fe),
    .stall_cycles(a_stl), .squash_cycles(a_sq)
  );

  branch_hazard_ctl #(.SPECULATE(1'b1)) i_branch_hazard_ctl_spec (
    .clk(clk), .rst_n(rst_n), .id_opcode(id_opcode), .ex_equal(ex_equal),
    .ex_target(ex_target), .pc_we(b_we), .pc_sel(b_sel), .pc_target(b_tgt),
    .ifid_flush(b_fi), .idex_flush(b_fd), .exmem_flush(b_fe),
    .stall_cycles(b_stl), .squash_cycles(b_sq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input string req, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] opc, input logic eq, input logic [15:0] tgt);
    @(negedge clk);
    id_opcode = opc;
    ex_equal  = eq;
    ex_target = tgt;
    #4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; id_opcode = '0; ex_equal = 1'b0; ex_target = '0;
    repeat (3) @(negedge clk);
    #4;
    // R1: state during reset
    chk("stall ctl in reset", "R1", {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, 16'b10000);
    chk("spec ctl in reset", "R1", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);
    chk("stall count in reset", "R1", a_stl, 16'd0);
    chk("squash count in reset", "R1", b_sq, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].opc, VECS[i].eq, VECS[i].tgt);
      chk($sformatf("stall vec %0d", i), "R3/R4/R6",
          {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, {11'd0, VECS[i].exp_stl});
      chk($sformatf("spec vec %0d", i), "R5/R6/R7",
          {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, {11'd0, VECS[i].exp_spc});
      if (VECS[i].exp_stl[3]) chk($sformatf("stall tgt %0d", i), "R11", a_tgt, VECS[i].exp_tgt);
      if (VECS[i].exp_spc[3]) chk($sformatf("spec tgt %0d", i), "R11", b_tgt, VECS[i].exp_tgt);
    end

    drive(3'd0, 1'b0, 16'h0);
    // R10: stall build 2+3+2 stall cycles, 2 squashes; speculate build 0 and 2
    chk("stall build stall count", "R10", a_stl, 16'd7);
    chk("stall build squash count", "R10", a_sq, 16'd2);
    chk("spec build stall count", "R10", b_stl, 16'd0);
    chk("spec build squash count", "R10", b_sq, 16'd2);

    // R8: younger control instructions discarded by a squash (speculate build)
    drive(3'd4, 1'b0, 16'h0);
    drive(3'd4, 1'b1, 16'h0AAA);
    drive(3'd4, 1'b1, 16'h0BBB);
    chk("spec squash cycle", "R8", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b11111);
    chk("spec squash target", "R8", b_tgt, 16'h0AAA);
    drive(3'd0, 1'b1, 16'h0CCC);
    chk("younger in EX dropped", "R8", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);
    drive(3'd0, 1'b1, 16'h0DDD);
    chk("younger in ID dropped", "R8", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);

    // R7: untaken then taken back to back (speculate build)
    drive(3'd4, 1'b0, 16'h0);
    drive(3'd4, 1'b0, 16'h0111);
    drive(3'd0, 1'b1, 16'h0222);
    chk("untaken no flush", "R7", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);
    drive(3'd0, 1'b0, 16'h0);
    chk("second branch redirects", "R7", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b11111);
    chk("second branch target", "R11", b_tgt, 16'h0222);

    // R1: reset with a branch in flight clears everything
    drive(3'd5, 1'b0, 16'h0);
    @(negedge clk);
    rst_n = 1'b0;
    id_opcode = 3'd0;
    #4;
    chk("stall ctl mid reset", "R1", {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, 16'b10000);
    chk("stall count cleared", "R1", a_stl, 16'd0);
    chk("squash count cleared", "R1", b_sq, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 1'b0, 16'h0);
    chk("stall no stale redirect", "R1", {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, 16'b10000);
    chk("spec no stale redirect", "R1", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);
    drive(3'd0, 1'b0, 16'h0);
    chk("spec no late redirect", "R1", {11'd0, b_we, b_sel, b_fi, b_fd, b_fe}, 16'b10000);

    // R3: a control opcode in decode while stalled is taken as a bubble
    drive(3'd4, 1'b0, 16'h0);
    drive(3'd4, 1'b0, 16'h0);
    drive(3'd4, 1'b0, 16'h0);
    chk("third bubble", "R3", {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, 16'b00100);
    drive(3'd0, 1'b0, 16'h0);
    chk("no extra stall", "R3", {11'd0, a_we, a_sel, a_fi, a_fd, a_fe}, 16'b10000);
    chk("stall count three", "R10", a_stl, 16'd3);

    finish_run();
  end

endmodule